// File: doc/BRIEF.md
# Shift Unit with Status Flags

This execution unit shifts an 8, 16 or 32-bit operand left, logically right or arithmetically right. It returns the shifted value together with updated carry, overflow, zero, sign and parity flags. The caller presents an operand, a size code, an operation code, a shift count and the current flag values, and raises a one-cycle strobe. The result and the new flags appear on registered outputs one clock later.

Only the low five bits of the count are used. Carry takes the last bit that left the operand. Overflow is meaningful only for a one-place shift, where it reports whether the top bit changed. A masked count of zero leaves the operand and every flag as they were. The auxiliary flag is never computed and always comes back unchanged.

Top module: `shift_flag_unit`

## Requirements
- R1: Only bits [4:0] of `in_cnt` set the shift distance. Bits [7:5] have no effect on the result or on any flag.
- R2: Operation codes 2'b00 and 2'b11 are both left shifts and give identical results and flags. Zeros enter at bit 0, and carry is the last bit pushed past the top of the selected size.
- R3: Operation code 2'b01 is a logical right shift. Zeros enter at the top of the selected size, and carry is the last bit pushed out of bit 0.
- R4: Operation code 2'b10 is an arithmetic right shift. Every vacated bit takes the operand's top bit at the selected size, and carry is the last bit pushed out of bit 0.
- R5: For a masked count of exactly one, overflow is 1 when the top bit of the result differs from the top bit of the operand, and 0 otherwise. An arithmetic right shift therefore always gives 0.
- R6: For a masked count of two or more, the overflow output is driven to 0.
- R7: For a nonzero masked count, zero is 1 exactly when the sized result is all zeros. Sign equals the result's top bit at the selected size.
- R8: For a nonzero masked count, parity is 1 when bits [7:0] of the result hold an even number of ones, whatever the size.
- R9: The auxiliary flag output always equals the `in_af` value presented with the strobe.
- R10: For a masked count of zero, the result equals the sized operand and all six flag outputs equal their inputs.
- R11: When the masked count is at least the operand width, logical shifts give 0 and arithmetic right shifts give copies of the sign bit. Carry is the bit that would have left last: 0 beyond the width for logical shifts, and the sign bit for arithmetic shifts.
- R12: `out_valid` is 1 exactly one clock after a cycle with `in_valid` high, and 0 otherwise. A synchronous active-high `rst` clears every output to 0.
- R13: Size code 2'b00 selects 8 bits and 2'b01 selects 16 bits. Codes 2'b10 and 2'b11 select 32 bits. Operand bits above the selected size are ignored, and result bits above it are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_opnd | input | 32 | Operand |
| in_size | input | 2 | Operand size code |
| in_op | input | 2 | Operation code |
| in_cnt | input | 8 | Shift count (low five bits used) |
| in_cf | input | 1 | Incoming carry flag |
| in_of | input | 1 | Incoming overflow flag |
| in_zf | input | 1 | Incoming zero flag |
| in_sf | input | 1 | Incoming sign flag |
| in_pf | input | 1 | Incoming parity flag |
| in_af | input | 1 | Incoming auxiliary flag |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| out_res | output | 32 | Shifted result, zero above the selected size |
| out_cf | output | 1 | Carry flag |
| out_of | output | 1 | Overflow flag |
| out_zf | output | 1 | Zero flag |
| out_sf | output | 1 | Sign flag |
| out_pf | output | 1 | Parity flag |
| out_af | output | 1 | Auxiliary flag (passed through) |

## Verification
Two behaviours can land in one cycle: the one-place overflow rule and the rule for counts past the width. A second pair is the carry that comes from discarded upper bits and a result that collapses to zero. The vector table provokes these together. Examples are an 8-bit left shift of 0x80 by two, which gives a zero result with carry clear, and an 8-bit shift by 33, which masks to one and so must report overflow. Each vector is judged against hand-derived result and carry values. Zero, sign and parity are then derived in the bench from the expected result.

// File: rtl/shu_pkg.sv
package shu_pkg;
  localparam int DATA_W  = 32;
  localparam int SHAMT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_SAR = 2'b10,
    OP_SAL = 2'b11
  } shu_op_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic zf;
    logic sf;
    logic pf;
    logic af;
  } shu_flags_t;

  // operand width selected by the size code
  function automatic logic [SHAMT_W:0] size_width(input logic [1:0] sz);
    case (sz)
      2'b00:   return (SHAMT_W+1)'(8);
      2'b01:   return (SHAMT_W+1)'(16);
      default: return (SHAMT_W+1)'(DATA_W);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return DATA_W'(32'h0000_00FF);
      2'b01:   return DATA_W'(32'h0000_FFFF);
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  // even number of ones in the low byte
  function automatic logic even_parity8(input logic [7:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/shu_core.sv
module shu_core
  import shu_pkg::*;
(
  input  logic [DATA_W-1:0]  opnd,
  input  logic [1:0]         size,
  input  logic [1:0]         op,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  opnd_sz,
  output logic [DATA_W-1:0]  res,
  output logic               carry,
  output logic               msb_in,
  output logic               msb_out
);
  localparam int WIDE_W = 2*DATA_W;

  logic [SHAMT_W:0]     wid;
  logic [DATA_W-1:0]    mask;
  logic                 top_bit;
  logic                 is_left;
  logic                 is_arith;
  logic [DATA_W-1:0]    ext;
  logic [WIDE_W-1:0]    lwide;
  logic signed [DATA_W+1:0] rvec;
  logic signed [DATA_W+1:0] rsh;

  assign wid      = size_width(size);
  assign mask     = size_mask(size);
  assign opnd_sz  = opnd & mask;
  assign top_bit  = opnd_sz[wid - 1'b1];
  assign is_left  = (op == OP_SHL) || (op == OP_SAL);
  assign is_arith = (op == OP_SAR);

  // left path: zero-extended operand, bit at index wid is the last bit out
  assign lwide = {{DATA_W{1'b0}}, opnd_sz} << shamt;

  // right path: fill-extended operand with a guard bit below bit 0
  assign ext  = (is_arith && top_bit) ? (opnd_sz | ~mask) : opnd_sz;
  assign rvec = {(is_arith & top_bit), ext, 1'b0};
  assign rsh  = rvec >>> shamt;

  always_comb begin
    if (is_left) begin
      res   = lwide[DATA_W-1:0] & mask;
      carry = lwide[wid];
    end else begin
      res   = rsh[DATA_W:1] & mask;
      carry = rsh[0];
    end
  end

  assign msb_in  = top_bit;
  assign msb_out = res[wid - 1'b1];
endmodule

// File: rtl/shu_flags.sv
module shu_flags
  import shu_pkg::*;
(
  input  logic [DATA_W-1:0]  res,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               carry,
  input  logic               msb_in,
  input  logic               msb_out,
  input  shu_flags_t         flags_in,
  output shu_flags_t         flags_out
);
  logic no_shift;
  logic single;

  assign no_shift = (shamt == '0);
  assign single   = (shamt == SHAMT_W'(1));

  always_comb begin
    flags_out = flags_in;
    if (!no_shift) begin
      flags_out.cf = carry;
      flags_out.of = single ? (msb_in ^ msb_out) : 1'b0;
      flags_out.zf = (res == '0);
      flags_out.sf = msb_out;
      flags_out.pf = even_parity8(res[7:0]);
    end
    flags_out.af = flags_in.af;
  end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic [1:0]        in_size,
  input  logic [1:0]        in_op,
  input  logic [CNT_W-1:0]  in_cnt,
  input  logic              in_cf,
  input  logic              in_of,
  input  logic              in_zf,
  input  logic              in_sf,
  input  logic              in_pf,
  input  logic              in_af,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_res,
  output logic              out_cf,
  output logic              out_of,
  output logic              out_zf,
  output logic              out_sf,
  output logic              out_pf,
  output logic              out_af
);
  logic [SHAMT_W-1:0] shamt;
  logic [DATA_W-1:0]  opnd_sz;
  logic [DATA_W-1:0]  res_c;
  logic               carry_c;
  logic               msb_in;
  logic               msb_out;
  shu_flags_t         flags_in;
  shu_flags_t         flags_c;
  shu_flags_t         flags_q;

  // count is taken modulo the operand register width
  assign shamt    = in_cnt[SHAMT_W-1:0];
  assign flags_in = '{cf: in_cf, of: in_of, zf: in_zf, sf: in_sf, pf: in_pf, af: in_af};

  shu_core u_core (
    .opnd    (in_opnd),
    .size    (in_size),
    .op      (in_op),
    .shamt   (shamt),
    .opnd_sz (opnd_sz),
    .res     (res_c),
    .carry   (carry_c),
    .msb_in  (msb_in),
    .msb_out (msb_out)
  );

  shu_flags u_flags (
    .res       (res_c),
    .shamt     (shamt),
    .carry     (carry_c),
    .msb_in    (msb_in),
    .msb_out   (msb_out),
    .flags_in  (flags_in),
    .flags_out (flags_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      flags_q   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res <= res_c;
        flags_q <= flags_c;
      end
    end
  end

  assign out_cf = flags_q.cf;
  assign out_of = flags_q.of;
  assign out_zf = flags_q.zf;
  assign out_sf = flags_q.sf;
  assign out_pf = flags_q.pf;
  assign out_af = flags_q.af;

  // R12: valid follows the strobe by exactly one clock
  p_valid_follow_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6: multi-place shifts report no overflow
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt > SHAMT_W'(1)) |=> !out_of);

  // R5: one-place arithmetic right shift never changes the top bit
  p_sar_one_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt == SHAMT_W'(1) && in_op == OP_SAR) |=> !out_of);

  // R9: auxiliary flag passes straight through
  p_af_pass_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_af == $past(in_af)));

  // R10: zero count leaves operand and carry untouched
  p_zero_cnt_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt == '0) |=> (out_res == $past(opnd_sz) && out_cf == $past(in_cf)));

  // R7: zero flag agrees with the registered result
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt != '0) |=> (out_zf == (out_res == '0)));

  // R13: nothing above the byte for 8-bit operations
  p_upper_clear_r13: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == 2'b00) |=> (out_res[DATA_W-1:8] == '0));
endmodule

// File: tb/shift_flag_unit_bench.sv
module shift_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_opnd = '0;
  logic [1:0]  in_size = '0;
  logic [1:0]  in_op = '0;
  logic [7:0]  in_cnt = '0;
  logic        in_cf = 1'b0, in_of = 1'b0, in_zf = 1'b0;
  logic        in_sf = 1'b0, in_pf = 1'b0, in_af = 1'b0;
  logic        out_valid;
  logic [31:0] out_res;
  logic        out_cf, out_of, out_zf, out_sf, out_pf, out_af;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shift_flag_unit u_shift_flag_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opnd(in_opnd),
    .in_size(in_size), .in_op(in_op), .in_cnt(in_cnt),
    .in_cf(in_cf), .in_of(in_of), .in_zf(in_zf), .in_sf(in_sf),
    .in_pf(in_pf), .in_af(in_af),
    .out_valid(out_valid), .out_res(out_res), .out_cf(out_cf),
    .out_of(out_of), .out_zf(out_zf), .out_sf(out_sf),
    .out_pf(out_pf), .out_af(out_af)
  );

  // {op, size, cnt, operand, expected result, expected cf, expected of}
  localparam int NV = 19;
  localparam logic [77:0] VEC [NV] = '{
    {2'b00, 2'b00, 8'd1,  32'h0000_0003, 32'h0000_0006, 1'b0, 1'b0}, // R2
    {2'b00, 2'b00, 8'd3,  32'h0000_003F, 32'h0000_00F8, 1'b1, 1'b0}, // R2
    {2'b00, 2'b01, 8'd1,  32'h0000_8F23, 32'h0000_1E46, 1'b1, 1'b1}, // R5
    {2'b11, 2'b01, 8'd1,  32'h0000_8F23, 32'h0000_1E46, 1'b1, 1'b1}, // R2 alias
    {2'b00, 2'b00, 8'd2,  32'h0000_0080, 32'h0000_0000, 1'b0, 1'b0}, // R7
    {2'b01, 2'b00, 8'd1,  32'h0000_0005, 32'h0000_0002, 1'b1, 1'b0}, // R3
    {2'b01, 2'b00, 8'd1,  32'h0000_0081, 32'h0000_0040, 1'b1, 1'b1}, // R5
    {2'b10, 2'b00, 8'd4,  32'h0000_0090, 32'h0000_00F9, 1'b0, 1'b0}, // R4
    {2'b10, 2'b01, 8'd1,  32'h0000_8001, 32'h0000_C000, 1'b1, 1'b0}, // R4 R5
    {2'b01, 2'b10, 8'd31, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0}, // R3
    {2'b00, 2'b11, 8'd31, 32'h0000_0003, 32'h8000_0000, 1'b1, 1'b0}, // R2
    {2'b00, 2'b00, 8'd33, 32'h0000_0041, 32'h0000_0082, 1'b0, 1'b1}, // R1
    {2'b00, 2'b00, 8'd8,  32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0}, // R11
    {2'b00, 2'b00, 8'd9,  32'h0000_00FF, 32'h0000_0000, 1'b0, 1'b0}, // R11
    {2'b01, 2'b01, 8'd16, 32'h0000_8000, 32'h0000_0000, 1'b1, 1'b0}, // R11
    {2'b10, 2'b00, 8'd20, 32'h0000_0080, 32'h0000_00FF, 1'b1, 1'b0}, // R11
    {2'b10, 2'b00, 8'd20, 32'h0000_007F, 32'h0000_0000, 1'b0, 1'b0}, // R11
    {2'b01, 2'b01, 8'd4,  32'hABCD_1234, 32'h0000_0123, 1'b0, 1'b0}, // R13
    {2'b00, 2'b00, 8'd4,  32'h1234_5678, 32'h0000_0080, 1'b1, 1'b0}  // R13
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] sz,
                       input logic [7:0] cnt, input logic [31:0] opnd,
                       input logic [5:0] fl);
    @(negedge clk);
    in_valid = 1'b1;
    in_op = op; in_size = sz; in_cnt = cnt; in_opnd = opnd;
    {in_cf, in_of, in_zf, in_sf, in_pf, in_af} = fl;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (400) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R12: reset clears outputs even with a strobe present
    in_valid = 1'b1; in_opnd = 32'hFFFF_FFFF; in_cnt = 8'd1;
    {in_cf, in_of, in_zf, in_sf, in_pf, in_af} = 6'h3F;
    repeat (3) @(negedge clk);
    check("R12", "reset valid", {31'b0, out_valid}, 32'h0);
    check("R12", "reset result", out_res, 32'h0);
    check("R12", "reset flags",
          {26'b0, out_cf, out_of, out_zf, out_sf, out_pf, out_af}, 32'h0);
    in_valid = 1'b0;
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op, sz;
      logic [7:0]  cnt;
      logic [31:0] opnd, eres;
      logic        ecf, eof, ezf, esf, epf, eaf;
      int          w;
      {op, sz, cnt, opnd, eres, ecf, eof} = VEC[i];
      w   = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
      ezf = (eres == 32'h0);                       // R7
      esf = eres[w-1];                             // R7
      epf = ~(^eres[7:0]);                         // R8
      eaf = i[0];                                  // R9
      issue(op, sz, cnt, opnd, {~ecf, ~eof, ~ezf, ~esf, ~epf, eaf});
      check("R12", "valid", {31'b0, out_valid}, 32'h1);
      check("R2/R3/R4/R11/R13", $sformatf("result v%0d", i), out_res, eres);
      check("R2/R3/R4/R11", $sformatf("carry v%0d", i), {31'b0, out_cf}, {31'b0, ecf});
      check("R5/R6", $sformatf("overflow v%0d", i), {31'b0, out_of}, {31'b0, eof});
      check("R7", $sformatf("zero v%0d", i), {31'b0, out_zf}, {31'b0, ezf});
      check("R7", $sformatf("sign v%0d", i), {31'b0, out_sf}, {31'b0, esf});
      check("R8", $sformatf("parity v%0d", i), {31'b0, out_pf}, {31'b0, epf});
      check("R9", $sformatf("aux v%0d", i), {31'b0, out_af}, {31'b0, eaf});
    end

    // R12: no strobe, no valid
    @(negedge clk);
    check("R12", "idle valid", {31'b0, out_valid}, 32'h0);

    // R10 and R1: count 32 masks to zero, all passes through
    issue(2'b01, 2'b10, 8'h20, 32'hDEAD_BEEF, 6'b110110);
    check("R10", "zero-count result", out_res, 32'hDEAD_BEEF);
    check("R10", "zero-count flags",
          {26'b0, out_cf, out_of, out_zf, out_sf, out_pf, out_af}, {26'b0, 6'b110110});

    // R10 with size 8: operand trimmed, flags kept
    issue(2'b10, 2'b00, 8'd0, 32'h1234_56AB, 6'b001001);
    check("R10", "zero-count byte", out_res, 32'h0000_00AB);
    check("R10", "zero-count byte flags",
          {26'b0, out_cf, out_of, out_zf, out_sf, out_pf, out_af}, {26'b0, 6'b001001});

    // R1: high count bits ignored (0xE3 masks to 3)
    issue(2'b00, 2'b01, 8'hE3, 32'h0000_2001, 6'b0);
    check("R1", "masked count result", out_res, 32'h0000_0008);
    check("R1", "masked count carry", {31'b0, out_cf}, 32'h1);

    // R8: parity from low byte only, 16-bit result 0x0300
    issue(2'b00, 2'b01, 8'd8, 32'h0000_0003, 6'b0);
    check("R8", "parity low byte", {31'b0, out_pf}, 32'h1);

    // R12: synchronous reset clears held outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12", "reset after run", out_res, 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule